// File: doc/BRIEF.md
# Self-Correcting Six-State JK Counter

This block is a 3-bit synchronous counter that walks through six of its eight binary codes in a fixed order. The next state is not produced by an adder. Each of the three state bits is updated by a JK-style cell, and the J and K inputs of each cell come from fixed equations of the current state. The bits are named A (bit 2), B (bit 1) and C (bit 0). The equations are:

- A: J = B, K = B
- B: J = C, K = 1
- C: J = not B, K = 1

Each cell reads its {J,K} pair as a two-bit action code: 00 holds the bit, 01 clears it, 10 sets it and 11 toggles it. The two codes outside the cycle, 011 and 111, are not trapped. The same equations send each of them into the valid cycle on the next clock, so no reset is needed to recover from an upset.

The named states are ST_ZERO (000), ST_ONE (001), ST_TWO (010), ST_FOUR (100), ST_FIVE (101) and ST_SIX (110). The valid transitions are ST_ZERO→ST_ONE, ST_ONE→ST_TWO, ST_TWO→ST_FOUR, ST_FOUR→ST_FIVE, ST_FIVE→ST_SIX and ST_SIX→ST_ZERO. The stray codes are ST_STRAY3 (011) and ST_STRAY7 (111). Their recovery transitions are ST_STRAY3→ST_FOUR and ST_STRAY7→ST_ZERO. An active-low asynchronous reset forces ST_ZERO.

Top module: `mod6_jk_counter`

## Requirements
- R1: While `rst_n` is 0 the output `count` is 000, taking effect at once without waiting for a clock edge, and staying 000 while clocks continue.
- R2: Out of reset the output follows 000, 001, 010, 100, 101, 110 and then back to 000, advancing one step on every rising clock edge.
- R3: Bit 2 (A) toggles on a clock edge when bit 1 (B) was 1, and holds when B was 0.
- R4: Bit 1 (B) becomes the inverse of its old value when bit 0 (C) was 1, and becomes 0 when C was 0.
- R5: Bit 0 (C) toggles when B was 0, and becomes 0 when B was 1.
- R6: From stray code 011 the counter reaches 100 on the next edge and then continues the normal cycle.
- R7: From stray code 111 the counter reaches 000 on the next edge and then continues the normal cycle.
- R8: From any valid code, the counter returns to the same code after exactly six clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to 000 |
| count | output | 3 | Current state, {A,B,C} |

## Verification
The riskiest corners are the two stray codes. The bench loads each one straight into the state register while reset is held low, then releases reset before the next clock edge. If 011 were mapped wrongly, the counter would land in the middle of the cycle, or it would lock into a loop of unused codes and never recover. If 111 were mapped wrongly, the counter would skip 000, or it would stick at 111.

A per-edge reference model catches several other faults. A swapped J/K pair or a toggle cell that acted as a set would show up as a wrong successor somewhere in the six-step walk, usually at 010 or 110, where A toggles and C clears. A reset applied in the middle of a cycle checks that the clear does not wait for the next edge. The six-edge period check exposes any sequence that is shorter or longer than six.

// File: rtl/mod6_jk_pkg.sv
`timescale 1ns/1ps
package mod6_jk_pkg;

    localparam int NUM_FF = 3;

    typedef enum logic [NUM_FF-1:0] {
        ST_ZERO   = 3'b000,
        ST_ONE    = 3'b001,
        ST_TWO    = 3'b010,
        ST_STRAY3 = 3'b011,
        ST_FOUR   = 3'b100,
        ST_FIVE   = 3'b101,
        ST_SIX    = 3'b110,
        ST_STRAY7 = 3'b111
    } cnt_state_e;

    // {J,K} read as an action code
    typedef enum logic [1:0] {
        JK_HOLD   = 2'b00,
        JK_CLEAR  = 2'b01,
        JK_SET    = 2'b10,
        JK_TOGGLE = 2'b11
    } jk_action_e;

endpackage

// File: rtl/jk_cell.sv
`timescale 1ns/1ps
module jk_cell
    import mod6_jk_pkg::*;
(
    input  logic q,
    input  logic j,
    input  logic k,
    output logic d
);

    jk_action_e action;

    always_comb begin
        action = jk_action_e'({j, k});
        unique case (action)
            JK_HOLD:   d = q;
            JK_CLEAR:  d = 1'b0;
            JK_SET:    d = 1'b1;
            JK_TOGGLE: d = ~q;
            default:   d = q;
        endcase
    end

endmodule

// File: rtl/mod6_jk_inputs.sv
`timescale 1ns/1ps
module mod6_jk_inputs
    import mod6_jk_pkg::*;
(
    input  cnt_state_e          state,
    output logic [NUM_FF-1:0]   j_vec,
    output logic [NUM_FF-1:0]   k_vec
);

    logic bit_a, bit_b, bit_c;

    always_comb begin
        bit_a = state[2];
        bit_b = state[1];
        bit_c = state[0];
        // bit 2 (A): toggles whenever B is set
        j_vec[2] = bit_b;
        k_vec[2] = bit_b;
        // bit 1 (B): toggles when C is set, else clears
        j_vec[1] = bit_c;
        k_vec[1] = 1'b1;
        // bit 0 (C): toggles when B is clear, else clears
        j_vec[0] = ~bit_b;
        k_vec[0] = 1'b1;
    end

    logic unused_a;
    assign unused_a = bit_a;

endmodule

// File: rtl/mod6_jk_counter.sv
`timescale 1ns/1ps
module mod6_jk_counter
    import mod6_jk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_FF-1:0]   count
);

    cnt_state_e           state_q;
    cnt_state_e           state_d;
    logic [NUM_FF-1:0]    j_vec;
    logic [NUM_FF-1:0]    k_vec;
    logic [NUM_FF-1:0]    d_vec;

    mod6_jk_inputs u_inputs (
        .state (state_q),
        .j_vec (j_vec),
        .k_vec (k_vec)
    );

    for (genvar i = 0; i < NUM_FF; i++) begin : g_cell
        jk_cell u_cell (
            .q (state_q[i]),
            .j (j_vec[i]),
            .k (k_vec[i]),
            .d (d_vec[i])
        );
    end

    always_comb begin
        state_d = cnt_state_e'(d_vec);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        count = state_q;
    end

endmodule

// File: rtl/mod6_jk_counter_chk.sv
`timescale 1ns/1ps
module mod6_jk_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] count
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> count == 3'b000); // R1

    AST_ZERO_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        count == 3'b000 |=> count == 3'b001); // R2

    AST_SIX_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        count == 3'b110 |=> count == 3'b000); // R2

    AST_A_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        count[1] |=> count[2] != $past(count[2])); // R3

    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !count[1] |=> $stable(count[2])); // R3

    AST_B_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !count[0] |=> !count[1]); // R4

    AST_C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        count[1] |=> !count[0]); // R5

    AST_STRAY3_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        count == 3'b011 |=> count == 3'b100); // R6

    AST_STRAY7_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        count == 3'b111 |=> count == 3'b000); // R7

endmodule

bind mod6_jk_counter mod6_jk_counter_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .count (count)
);

// File: tb/mod6_jk_counter_tb.sv
`timescale 1ns/1ps
module mod6_jk_counter_tb;
    import mod6_jk_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [2:0] count;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_val = 0;
    int ring[$] = '{0, 1, 2, 4, 5, 6};

    always #2.5 clk = ~clk;

    mod6_jk_counter u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    function automatic int ref_next(int cur);
        for (int i = 0; i < ring.size(); i++)
            if (ring[i] == cur) return ring[(i + 1) % ring.size()];
        if (cur == 3) return 4;
        return 0;
    endfunction

    task automatic check(int got, int want, string tag);
        n_cmp++;
        if (got != want) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected=%0d", tag, got, want);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        exp_val = ref_next(exp_val);
        @(negedge clk);
        check(int'(count), exp_val, tag);
    endtask

    task automatic inject(bit seven);
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        if (seven) force u_dut.state_q = ST_STRAY7;
        else       force u_dut.state_q = ST_STRAY3;
        #0.5;
        release u_dut.state_q;
        #0.5;
        rst_n = 1'b1;
        exp_val = seven ? 7 : 3;
        check(int'(count), exp_val, seven ? "R7 load" : "R6 load");
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: count=%0d expected=%0d", count, exp_val);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int keep;
        #1 rst_n = 1'b0;
        #0.5 check(int'(count), 0, "R1 immediate");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(int'(count), 0, "R1 hold");
        end
        rst_n = 1'b1;
        exp_val = 0;

        // main cycle, per-bit rules covered by the model
        for (int i = 0; i < 14; i++) tick("R2 R3 R4 R5");

        // period of six
        keep = int'(count);
        for (int i = 0; i < 6; i++) tick("R2");
        check(int'(count), keep, "R8");
        tick("R2");
        keep = int'(count);
        for (int i = 0; i < 6; i++) tick("R2");
        check(int'(count), keep, "R8");

        // asynchronous reset in mid cycle
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5 check(int'(count), 0, "R1 async");
        @(negedge clk);
        check(int'(count), 0, "R1 hold");
        rst_n = 1'b1;
        exp_val = 0;
        tick("R2 after reset");

        // stray code 011
        inject(1'b0);
        tick("R6 exit");
        check(int'(count), 4, "R6 target");
        for (int i = 0; i < 7; i++) tick("R6 resume");

        // stray code 111
        inject(1'b1);
        tick("R7 exit");
        check(int'(count), 0, "R7 target");
        for (int i = 0; i < 7; i++) tick("R7 resume");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule